// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a translation-buffer miss by reading the page tables in physical memory. It is given the page number that missed, the number of the current address space (the context) and the physical base of the context table. It first reads the context entry, which points to the first-level table. It then descends through up to three levels of tables, one memory read per level. All table reads use physical addresses that need no translation.

Every entry read carries a 2-bit kind field. A pointer entry sends the walk down one level. A mapping (leaf) entry ends the walk. The block then emits a one-cycle fill carrying the physical page number, the permission flags and the level at which the walk stopped. A leaf found above the last level maps a larger region, so the virtual page bits below that level pass straight into the physical page number. A missing entry, a reserved kind, a pointer where no further level exists, or a leaf in the context table ends the walk with a one-cycle fault that reports the level.

Only one walk runs at a time. A new miss is taken only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `ready_o` is 1 and `mem_req_o`, `fill_valid_o` and `fault_o` are 0.
- R2: A miss is accepted only when `ready_o` is 1. `ready_o` is 1 only while idle. A miss presented during a walk is ignored: it causes no memory read and does not change the result.
- R3: The first read of every walk is at `ctx_base_i + miss_ctx_i*4`.
- R4: The indices are taken from the virtual address, where virtual bit k equals `miss_vpn_i` bit k-12. Level 1 uses bits 31..24, level 2 uses bits 23..18 and level 3 uses bits 17..12. Each read is at table base + index*4. The table base is the pointer entry with bits 7..0 cleared.
- R5: Entry bits 1..0 encode the kind: 0 missing, 1 pointer, 2 leaf, 3 reserved. A pointer in the context entry or at level 1 or 2 causes a read of the next level.
- R6: On a level-3 leaf, `fill_ppn_o` is entry bits 31..12 and `fill_flags_o` is entry bits 7..2. `fill_vpn_o` is the missed page number and `fill_lvl_o` is 3.
- R7: On a level-1 leaf, `fill_ppn_o` is {entry[31:24], va[23:12]} and `fill_lvl_o` is 1. On a level-2 leaf, `fill_ppn_o` is {entry[31:18], va[17:12]} and `fill_lvl_o` is 2.
- R8: A missing or reserved entry raises `fault_o` with `fault_lvl_o` set to the level read: 0 for the context entry, 1 to 3 for the tables. No fill is produced.
- R9: A leaf in the context entry faults at level 0. A pointer at level 3 faults at level 3.
- R10: The block issues exactly one read per level visited. `mem_req_o` is a one-cycle pulse, and no new request is made before the response to the previous one.
- R11: `fill_valid_o` and `fault_o` are one-cycle pulses and are never both 1. `ready_o` is 1 in the cycle either pulse is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request strobe |
| miss_vpn_i | input | 20 | Virtual page number that missed |
| miss_ctx_i | input | 8 | Context number of the access |
| ctx_base_i | input | 32 | Physical base of the context table |
| ready_o | output | 1 | Walker idle, miss can be taken |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Physical address of the entry to read |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Entry returned by memory |
| fill_valid_o | output | 1 | Translation ready for the buffer |
| fill_vpn_o | output | 20 | Virtual page of the fill |
| fill_ppn_o | output | 20 | Physical page of the fill |
| fill_flags_o | output | 6 | Permission flags from the leaf |
| fill_lvl_o | output | 2 | Level at which the leaf was found |
| fault_o | output | 1 | Walk ended in a page fault |
| fault_lvl_o | output | 2 | Level at which the walk failed |

## Verification
The walk is tried with these patterns:
- A full four-read walk to a level-3 leaf.
- Early leaves at levels 1 and 2, whose physical page numbers differ only in how many virtual bits pass through. These tell apart the pass-through widths.
- Missing and reserved entries at each table level. These separate the reported fault levels.
- A leaf in the context entry and a pointer at level 3. These catch a walker that accepts an entry kind in the wrong place.

The read count and the address of each read show the index slicing and scaling. A second context-table base, a slower memory and a miss presented mid-walk show that the root address follows its inputs, that the walker waits for each response, and that a busy walker ignores new requests.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    ENT_NONE = 2'd0,
    ENT_NEXT = 2'd1,
    ENT_MAP  = 2'd2,
    ENT_RSVD = 2'd3
  } ent_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } walk_st_e;

  localparam logic [1:0] LVL_ROOT = 2'd0;
  localparam logic [1:0] LVL_LAST = 2'd3;
endpackage

// File: rtl/pt_walker_addr.sv
module pt_walker_addr #(
  parameter int unsigned CTX_W  = 8,
  parameter int unsigned IDX1_W = 8,
  parameter int unsigned IDX2_W = 6,
  parameter int unsigned IDX3_W = 6,
  parameter int unsigned PA_W   = 32,
  localparam int unsigned VPN_W = IDX1_W + IDX2_W + IDX3_W
) (
  input  logic [1:0]       lvl_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [CTX_W-1:0] ctx_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [PA_W-1:0] scaled [4];

  // entries are 4 bytes: index << 2
  assign scaled[0] = PA_W'({ctx_i, 2'b00});
  assign scaled[1] = PA_W'({vpn_i[VPN_W-1 -: IDX1_W], 2'b00});
  assign scaled[2] = PA_W'({vpn_i[IDX3_W +: IDX2_W], 2'b00});
  assign scaled[3] = PA_W'({vpn_i[0 +: IDX3_W], 2'b00});

  assign addr_o = base_i + scaled[lvl_i];
endmodule

// File: rtl/pt_walker_dec.sv
module pt_walker_dec
  import pt_walker_pkg::*;
#(
  parameter int unsigned IDX1_W  = 8,
  parameter int unsigned IDX2_W  = 6,
  parameter int unsigned IDX3_W  = 6,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned FLAG_W  = 6,
  parameter int unsigned PTR_LSB = 8,
  localparam int unsigned VPN_W  = IDX1_W + IDX2_W + IDX3_W,
  localparam int unsigned PPN_W  = PA_W - OFF_W
) (
  input  logic [PA_W-1:0]   ent_i,
  input  logic [1:0]        lvl_i,
  input  logic [VPN_W-1:0]  vpn_i,
  output ent_kind_e         kind_o,
  output logic [PA_W-1:0]   next_base_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [PPN_W-1:0] ent_ppn;
  logic [PPN_W-1:0] vpn_ext;
  logic [PPN_W-1:0] cand [1:3];

  assign kind_o      = ent_kind_e'(ent_i[1:0]);
  assign flags_o     = ent_i[FLAG_W+1:2];
  assign next_base_o = {ent_i[PA_W-1:PTR_LSB], {PTR_LSB{1'b0}}};
  assign ent_ppn     = ent_i[PA_W-1:OFF_W];
  assign vpn_ext     = PPN_W'(vpn_i);

  // leaf above the last level: lower index bits pass through
  for (genvar g = 1; g <= 3; g++) begin : g_leaf
    localparam int unsigned SH = (g == 1) ? IDX2_W + IDX3_W :
                                 (g == 2) ? IDX3_W : 0;
    localparam logic [PPN_W-1:0] KEEP = PPN_W'((64'd1 << SH) - 64'd1);
    assign cand[g] = (ent_ppn & ~KEEP) | (vpn_ext & KEEP);
  end

  always_comb begin
    case (lvl_i)
      2'd1:    ppn_o = cand[1];
      2'd2:    ppn_o = cand[2];
      default: ppn_o = cand[3];
    endcase
  end
endmodule

// File: rtl/pt_walker_fsm.sv
module pt_walker_fsm
  import pt_walker_pkg::*;
#(
  parameter int unsigned CTX_W  = 8,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PPN_W  = 20,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned FLAG_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [VPN_W-1:0]  miss_vpn_i,
  input  logic [CTX_W-1:0]  miss_ctx_i,
  input  logic [PA_W-1:0]   ctx_base_i,
  input  logic              mem_rvalid_i,
  input  ent_kind_e         kind_i,
  input  logic [PA_W-1:0]   next_base_i,
  input  logic [PPN_W-1:0]  leaf_ppn_i,
  input  logic [FLAG_W-1:0] leaf_flags_i,
  output logic              ready_o,
  output logic              mem_req_o,
  output logic [1:0]        lvl_o,
  output logic [PA_W-1:0]   base_o,
  output logic [VPN_W-1:0]  vpn_o,
  output logic [CTX_W-1:0]  ctx_o,
  output logic              fill_valid_o,
  output logic [PPN_W-1:0]  fill_ppn_o,
  output logic [FLAG_W-1:0] fill_flags_o,
  output logic [1:0]        fill_lvl_o,
  output logic              fault_o,
  output logic [1:0]        fault_lvl_o
);
  walk_st_e          state_q;
  logic [1:0]        lvl_q;
  logic [PA_W-1:0]   base_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [CTX_W-1:0]  ctx_q;
  logic              fill_q, fault_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [FLAG_W-1:0] flags_q;
  logic [1:0]        fill_lvl_q, fault_lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lvl_q       <= LVL_ROOT;
      base_q      <= '0;
      vpn_q       <= '0;
      ctx_q       <= '0;
      fill_q      <= 1'b0;
      fault_q     <= 1'b0;
      ppn_q       <= '0;
      flags_q     <= '0;
      fill_lvl_q  <= '0;
      fault_lvl_q <= '0;
    end else begin
      fill_q  <= 1'b0;
      fault_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (miss_valid_i) begin
            vpn_q   <= miss_vpn_i;
            ctx_q   <= miss_ctx_i;
            base_q  <= ctx_base_i;
            lvl_q   <= LVL_ROOT;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            state_q <= ST_IDLE;
            case (kind_i)
              ENT_NEXT: begin
                if (lvl_q != LVL_LAST) begin
                  base_q  <= next_base_i;
                  lvl_q   <= lvl_q + 2'd1;
                  state_q <= ST_ISSUE;
                end else begin
                  fault_q     <= 1'b1;
                  fault_lvl_q <= lvl_q;
                end
              end
              ENT_MAP: begin
                if (lvl_q != LVL_ROOT) begin
                  fill_q     <= 1'b1;
                  ppn_q      <= leaf_ppn_i;
                  flags_q    <= leaf_flags_i;
                  fill_lvl_q <= lvl_q;
                end else begin
                  fault_q     <= 1'b1;
                  fault_lvl_q <= lvl_q;
                end
              end
              default: begin
                fault_q     <= 1'b1;
                fault_lvl_q <= lvl_q;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o      = (state_q == ST_IDLE);
  assign mem_req_o    = (state_q == ST_ISSUE);
  assign lvl_o        = lvl_q;
  assign base_o       = base_q;
  assign vpn_o        = vpn_q;
  assign ctx_o        = ctx_q;
  assign fill_valid_o = fill_q;
  assign fill_ppn_o   = ppn_q;
  assign fill_flags_o = flags_q;
  assign fill_lvl_o   = fill_lvl_q;
  assign fault_o      = fault_q;
  assign fault_lvl_o  = fault_lvl_q;

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && miss_valid_i) |=> (!ready_o && mem_req_o));
  p_req_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (!mem_req_o && !ready_o));
  p_fill_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |=> !fill_valid_o);
  p_fault_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned CTX_W   = 8,
  parameter int unsigned IDX1_W  = 8,
  parameter int unsigned IDX2_W  = 6,
  parameter int unsigned IDX3_W  = 6,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned FLAG_W  = 6,
  parameter int unsigned PTR_LSB = 8,
  localparam int unsigned VPN_W  = IDX1_W + IDX2_W + IDX3_W,
  localparam int unsigned PPN_W  = PA_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [VPN_W-1:0]  miss_vpn_i,
  input  logic [CTX_W-1:0]  miss_ctx_i,
  input  logic [PA_W-1:0]   ctx_base_i,
  output logic              ready_o,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PA_W-1:0]   mem_rdata_i,
  output logic              fill_valid_o,
  output logic [VPN_W-1:0]  fill_vpn_o,
  output logic [PPN_W-1:0]  fill_ppn_o,
  output logic [FLAG_W-1:0] fill_flags_o,
  output logic [1:0]        fill_lvl_o,
  output logic              fault_o,
  output logic [1:0]        fault_lvl_o
);
  logic [1:0]        lvl;
  logic [PA_W-1:0]   base;
  logic [VPN_W-1:0]  vpn;
  logic [CTX_W-1:0]  ctx;
  ent_kind_e         kind;
  logic [PA_W-1:0]   next_base;
  logic [PPN_W-1:0]  leaf_ppn;
  logic [FLAG_W-1:0] leaf_flags;

  pt_walker_addr #(
    .CTX_W(CTX_W), .IDX1_W(IDX1_W), .IDX2_W(IDX2_W), .IDX3_W(IDX3_W), .PA_W(PA_W)
  ) u_addr (
    .lvl_i(lvl), .base_i(base), .vpn_i(vpn), .ctx_i(ctx), .addr_o(mem_addr_o)
  );

  pt_walker_dec #(
    .IDX1_W(IDX1_W), .IDX2_W(IDX2_W), .IDX3_W(IDX3_W), .OFF_W(OFF_W),
    .PA_W(PA_W), .FLAG_W(FLAG_W), .PTR_LSB(PTR_LSB)
  ) u_dec (
    .ent_i(mem_rdata_i), .lvl_i(lvl), .vpn_i(vpn), .kind_o(kind),
    .next_base_o(next_base), .ppn_o(leaf_ppn), .flags_o(leaf_flags)
  );

  pt_walker_fsm #(
    .CTX_W(CTX_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .PA_W(PA_W), .FLAG_W(FLAG_W)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .miss_valid_i(miss_valid_i), .miss_vpn_i(miss_vpn_i), .miss_ctx_i(miss_ctx_i),
    .ctx_base_i(ctx_base_i), .mem_rvalid_i(mem_rvalid_i),
    .kind_i(kind), .next_base_i(next_base), .leaf_ppn_i(leaf_ppn), .leaf_flags_i(leaf_flags),
    .ready_o(ready_o), .mem_req_o(mem_req_o),
    .lvl_o(lvl), .base_o(base), .vpn_o(vpn), .ctx_o(ctx),
    .fill_valid_o(fill_valid_o), .fill_ppn_o(fill_ppn_o), .fill_flags_o(fill_flags_o),
    .fill_lvl_o(fill_lvl_o), .fault_o(fault_o), .fault_lvl_o(fault_lvl_o)
  );

  assign fill_vpn_o = vpn;

  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_o && fault_o));
  p_done_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o || fault_o) |-> ready_o);
  p_no_req_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);
  p_fill_lvl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> (fill_lvl_o != 2'd0));
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        miss_valid_i = 1'b0;
  logic [19:0] miss_vpn_i = '0;
  logic [7:0]  miss_ctx_i = '0;
  logic [31:0] ctx_base_i = 32'h100;
  logic        ready_o, mem_req_o, mem_rvalid_i, fill_valid_o, fault_o;
  logic [31:0] mem_addr_o, mem_rdata_i;
  logic [19:0] fill_vpn_o, fill_ppn_o;
  logic [5:0]  fill_flags_o;
  logic [1:0]  fill_lvl_o, fault_lvl_o;

  always #10 clk_i = ~clk_i; // 50 MHz

  pt_walker dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .miss_valid_i(miss_valid_i), .miss_vpn_i(miss_vpn_i),
    .miss_ctx_i(miss_ctx_i), .ctx_base_i(ctx_base_i), .ready_o(ready_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .fill_valid_o(fill_valid_o), .fill_vpn_o(fill_vpn_o),
    .fill_ppn_o(fill_ppn_o), .fill_flags_o(fill_flags_o), .fill_lvl_o(fill_lvl_o),
    .fault_o(fault_o), .fault_lvl_o(fault_lvl_o)
  );

  // memory model
  logic [31:0] mem [0:4095];
  logic [31:0] rlog [0:63];
  logic [31:0] paddr;
  logic        pend;
  int          cnt, lat, nreads, overlap;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_rvalid_i <= 1'b0; mem_rdata_i <= '0; pend <= 1'b0; cnt <= 0;
      nreads <= 0; overlap <= 0; paddr <= '0;
    end else begin
      mem_rvalid_i <= 1'b0;
      if (mem_req_o) begin
        if (pend) overlap <= overlap + 1;
        pend <= 1'b1; cnt <= lat - 1; paddr <= mem_addr_o;
        rlog[nreads % 64] <= mem_addr_o;
        nreads <= nreads + 1;
      end else if (pend) begin
        if (cnt == 0) begin
          mem_rvalid_i <= 1'b1; mem_rdata_i <= mem[paddr[13:2]]; pend <= 1'b0;
        end else cnt <= cnt - 1;
      end
    end
  end

  int errors = 0, checks = 0, cyc = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  typedef struct packed {
    logic [7:0]  ctx;
    logic [19:0] vpn;
    logic        flt;
    logic [1:0]  lvl;
    logic [19:0] ppn;
    logic [5:0]  flags;
    logic [2:0]  nrd;
    logic [31:0] last;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 20'h00000, 1'b0, 2'd3, 20'hCAFEF, 6'h02, 3'd4, 32'h900}, // R6 deep leaf
    '{8'd1, 20'h05ABC, 1'b0, 2'd1, 20'hABABC, 6'h3D, 3'd2, 32'h414}, // R7 L1 leaf
    '{8'd1, 20'h00FD5, 1'b0, 2'd2, 20'h12355, 6'h01, 3'd3, 32'h8FC}, // R7 L2 leaf
    '{8'd1, 20'h07000, 1'b1, 2'd1, 20'h0,     6'h0,  3'd2, 32'h41C}, // R8 missing L1
    '{8'd1, 20'h09000, 1'b1, 2'd1, 20'h0,     6'h0,  3'd2, 32'h424}, // R8 reserved L1
    '{8'd1, 20'h00080, 1'b1, 2'd2, 20'h0,     6'h0,  3'd3, 32'h808}, // R8 missing L2
    '{8'd1, 20'h0003F, 1'b1, 2'd3, 20'h0,     6'h0,  3'd4, 32'h9FC}, // R9 pointer at L3
    '{8'd1, 20'h00010, 1'b1, 2'd3, 20'h0,     6'h0,  3'd4, 32'h940}, // R8 missing L3
    '{8'd2, 20'h00000, 1'b1, 2'd0, 20'h0,     6'h0,  3'd1, 32'h108}, // R9 leaf in context
    '{8'd3, 20'h00000, 1'b1, 2'd0, 20'h0,     6'h0,  3'd1, 32'h10C}  // R8 missing context
  };

  logic        r_flt;
  logic [1:0]  r_lvl;
  logic [19:0] r_ppn, r_vpn;
  logic [5:0]  r_fl;
  int          r_nrd;
  logic [31:0] r_first, r_last;

  task automatic walk(input logic [7:0] ctx, input logic [19:0] vpn);
    int s;
    s = nreads;
    miss_valid_i = 1'b1; miss_ctx_i = ctx; miss_vpn_i = vpn;
    @(negedge clk_i);
    miss_valid_i = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (fill_valid_o || fault_o) break;
      @(negedge clk_i);
    end
    r_flt = fault_o;
    r_lvl = fault_o ? fault_lvl_o : fill_lvl_o;
    r_ppn = fill_ppn_o; r_fl = fill_flags_o; r_vpn = fill_vpn_o;
    chk("R11", "one of fill/fault", {31'b0, fill_valid_o ^ fault_o}, 32'd1);
    chk("R11", "ready with result", {31'b0, ready_o}, 32'd1);
    r_nrd = nreads - s;
    r_first = rlog[s % 64];
    r_last = rlog[(nreads - 1) % 64];
    @(negedge clk_i);
    chk("R11", "pulse ends", {30'b0, fill_valid_o, fault_o}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[32'h104 >> 2] = 32'h0000_0401;
    mem[32'h108 >> 2] = 32'h0000_0402;
    mem[32'h400 >> 2] = 32'h0000_0801;
    mem[32'h414 >> 2] = 32'hAB00_00F6;
    mem[32'h424 >> 2] = 32'h0000_0003;
    mem[32'h800 >> 2] = 32'h0000_0901;
    mem[32'h8FC >> 2] = 32'h1234_4006;
    mem[32'h900 >> 2] = 32'hCAFE_F00A;
    mem[32'h9FC >> 2] = 32'h0000_0C01;
    mem[32'h2004 >> 2] = 32'h0000_0401;
    lat = 1;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "ready", {31'b0, ready_o}, 32'd1);
    chk("R1", "req/fill/fault", {29'b0, mem_req_o, fill_valid_o, fault_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      walk(VECS[v].ctx, VECS[v].vpn);
      chk("R8", $sformatf("v%0d fault flag", v), {31'b0, r_flt}, {31'b0, VECS[v].flt});
      chk("R8", $sformatf("v%0d level", v), {30'b0, r_lvl}, {30'b0, VECS[v].lvl});
      chk("R10", $sformatf("v%0d reads", v), r_nrd, {29'b0, VECS[v].nrd});
      chk("R4", $sformatf("v%0d last addr", v), r_last, VECS[v].last);
      chk("R3", $sformatf("v%0d ctx addr", v), r_first, 32'h100 + {22'b0, VECS[v].ctx, 2'b00});
      if (!VECS[v].flt) begin
        chk("R7", $sformatf("v%0d ppn", v), {12'b0, r_ppn}, {12'b0, VECS[v].ppn});
        chk("R6", $sformatf("v%0d flags", v), {26'b0, r_fl}, {26'b0, VECS[v].flags});
        chk("R6", $sformatf("v%0d vpn", v), {12'b0, r_vpn}, {12'b0, VECS[v].vpn});
      end
    end

    // R5 pointer chain: second read of deep walk is L1 entry 0 at 0x400
    walk(8'd1, 20'h00000);
    chk("R5", "second read", rlog[(nreads - 3) % 64], 32'h400);
    chk("R5", "third read", rlog[(nreads - 2) % 64], 32'h800);

    // R3 other context-table base
    ctx_base_i = 32'h2000;
    walk(8'd1, 20'h00FD5);
    chk("R3", "alt base addr", r_first, 32'h2004);
    chk("R7", "alt base ppn", {12'b0, r_ppn}, 32'h12355);
    ctx_base_i = 32'h100;

    // R10 slow memory
    lat = 3;
    walk(8'd1, 20'h00000);
    chk("R10", "slow reads", r_nrd, 32'd4);
    chk("R6", "slow ppn", {12'b0, r_ppn}, 32'hCAFEF);

    // R2 miss while busy is ignored
    begin
      int s;
      s = nreads;
      miss_valid_i = 1'b1; miss_ctx_i = 8'd1; miss_vpn_i = 20'h00000;
      @(negedge clk_i);
      miss_valid_i = 1'b0;
      @(negedge clk_i); @(negedge clk_i);
      chk("R2", "busy ready low", {31'b0, ready_o}, 32'd0);
      miss_valid_i = 1'b1; miss_vpn_i = 20'h05ABC;
      @(negedge clk_i);
      miss_valid_i = 1'b0;
      for (int i = 0; i < 200; i++) begin
        if (fill_valid_o || fault_o) break;
        @(negedge clk_i);
      end
      chk("R2", "busy result ppn", {12'b0, fill_ppn_o}, 32'hCAFEF);
      chk("R2", "busy result vpn", {12'b0, fill_vpn_o}, 32'h0);
      chk("R2", "busy reads", nreads - s, 32'd4);
      s = nreads;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk_i);
        if (fill_valid_o || fault_o || mem_req_o) s = -1;
      end
      chk("R2", "quiet after walk", (s == nreads) ? 32'd1 : 32'd0, 32'd1);
    end

    chk("R10", "no overlapping requests", overlap, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule